// File: doc/BRIEF.md
# UART Line Configuration Guard

This block is the register front end of a 16550-style UART that owns the line control byte and the baud divisor. Software reaches it over a byte-wide bus that carries a word index, a write strobe, a read strobe and write data. Reads return data in the same cycle. The serializer reports whether it is busy, marks character boundaries, and supplies the fill levels of both FIFOs. The block drives the active line control and divisor values back to the serializer. It also merges the interrupt sources into one request line and an identification code.

While the serializer is busy, a plain write to the line control byte or to a divisor byte is refused and raises a busy interrupt. Software clears that interrupt by reading the status register. To reconfigure a running line, software first sets the stage-enable bit of the halt register. It then writes the new settings, which land only in shadow copies. Next it sets the update bit and polls until the hardware clears it. The hardware copies all shadow values to the active registers in one clock cycle, either when the engine is idle or on a character boundary.

Top module: `uart_lcr_guard`

## Requirements
- R1: After reset the active line control is 0x00, the active divisor is 0x0000, the halt register reads 0x00, `irq_o` is 0 and the identification register (index 2) reads 0x01.
- R2: With the engine idle and stage-enable clear, a write to the line control byte (index 3) or to a divisor byte appears on `lcr_o` / `divisor_o` on the clock edge that takes the write.
- R3: With the engine busy and stage-enable clear, a line control write is dropped. It sets the busy interrupt: `irq_o` goes high and the identification register reads 0x07.
- R4: Status register (index 31) bit 0 equals `busy_i`, and all other bits read 0. A read of it clears the busy interrupt, after which the identification register reads 0x01 if no other source is active.
- R5: Index 32 returns the transmit FIFO level and index 33 the receive FIFO level, both zero-extended. Writes to these indices change nothing.
- R6: Halt register (index 41) bit 1 is stage-enable. While it is 1, line control and divisor writes go only to shadow copies, whatever the busy state. Reads of indices 0, 1 and 3 return the staged values, while the active outputs hold.
- R7: Halt register bit 2 requests an update. The shadow line control and both divisor bytes are copied to the active outputs in one cycle, on the first edge after the request where `busy_i` is low or `char_bound_i` is high. Bit 2 then reads 0. While busy with no boundary, the request stays pending.
- R8: When bit 7 of the (staged) line control is 1, indices 0 and 1 access the divisor low and high bytes. When it is 0, a read of index 0 returns `rx_data_i`, and a write of index 0 pulses `tx_push_o` with `tx_data_o` equal to the write data.
- R9: The identification code in bits 3:0 follows a fixed priority: line status 0x6, then receive data 0x4, then transmit empty 0x2, then busy 0x7, else 0x1. `irq_o` is high whenever any source is active.
- R10: With the engine busy and stage-enable clear, a divisor byte write is dropped and sets the busy interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 6 | Register word index |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, same cycle as the strobe |
| busy_i | input | 1 | Serializer busy |
| char_bound_i | input | 1 | Character boundary pulse from the serializer |
| tx_level_i | input | 7 | Transmit FIFO fill level |
| rx_level_i | input | 7 | Receive FIFO fill level |
| rx_data_i | input | 8 | Head of the receive FIFO |
| rls_irq_i | input | 1 | Receive line status interrupt source |
| rx_irq_i | input | 1 | Receive data interrupt source |
| thre_irq_i | input | 1 | Transmit empty interrupt source |
| lcr_o | output | 8 | Active line control value |
| divisor_o | output | 16 | Active baud divisor |
| tx_push_o | output | 1 | Transmit data write pulse |
| tx_data_o | output | 8 | Transmit data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The checker watches several rules on every cycle. A refused write must leave `lcr_o` untouched and raise the interrupt, and active outputs must stay frozen while staging with no update pending. A pending update must clear as soon as the engine goes idle and must persist while busy with no boundary. A status read must drop the busy flag, and line status must win the identification code. Other behaviour shows only in the bench's ordered scenarios. These include the staged values read back through the bus, the single-cycle commit on a character boundary, and the address decode switching with the divisor-access bit. They also include the read-only level registers, the full priority ladder and reset in mid-run.

// File: rtl/uart_cfg_pkg.sv
`timescale 1ns/1ps
package uart_cfg_pkg;
  localparam int DATA_W    = 8;
  localparam int DIV_BYTES = 2;
  localparam int DIV_W     = DATA_W * DIV_BYTES;

  localparam int IDX_IIR  = 2;
  localparam int IDX_LCR  = 3;
  localparam int IDX_USR  = 31;
  localparam int IDX_TFL  = 32;
  localparam int IDX_RFL  = 33;
  localparam int IDX_HALT = 41;

  localparam int LCR_DLAB_BIT = 7;
  localparam int HALT_EN_BIT  = 1;
  localparam int HALT_UPD_BIT = 2;

  typedef enum logic [3:0] {
    IIR_NONE = 4'h1,
    IIR_THRE = 4'h2,
    IIR_RXD  = 4'h4,
    IIR_RLS  = 4'h6,
    IIR_BUSY = 4'h7
  } iir_code_e;

  typedef struct packed {
    logic                 wr_lcr;
    logic                 wr_halt;
    logic                 wr_thr;
    logic                 rd_usr;
    logic [DIV_BYTES-1:0] wr_div;
  } cfg_strobe_t;
endpackage

// File: rtl/uart_cfg_decode.sv
`timescale 1ns/1ps
module uart_cfg_decode
  import uart_cfg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              dlab_i,
  output cfg_strobe_t       strb_o
);
  always_comb begin
    strb_o.wr_lcr  = wr_i && (addr_i == ADDR_W'(IDX_LCR));
    strb_o.wr_halt = wr_i && (addr_i == ADDR_W'(IDX_HALT));
    strb_o.wr_thr  = wr_i && !dlab_i && (addr_i == '0);
    strb_o.rd_usr  = rd_i && (addr_i == ADDR_W'(IDX_USR));
  end

  for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div_dec
    assign strb_o.wr_div[b] = wr_i && dlab_i && (addr_i == ADDR_W'(b));
  end
endmodule

// File: rtl/uart_cfg_shadow.sv
`timescale 1ns/1ps
module uart_cfg_shadow
  import uart_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cfg_strobe_t       strb_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              char_bound_i,
  output logic [DATA_W-1:0] act_lcr_o,
  output logic [DIV_W-1:0]  act_div_o,
  output logic [DATA_W-1:0] sh_lcr_o,
  output logic [DIV_W-1:0]  sh_div_o,
  output logic              halt_en_o,
  output logic              halt_upd_o,
  output logic              busy_irq_o
);
  logic cfg_wr, blocked, direct, accept, commit;

  assign cfg_wr  = strb_i.wr_lcr || (|strb_i.wr_div);
  assign blocked = cfg_wr && busy_i && !halt_en_o;
  assign direct  = cfg_wr && !busy_i && !halt_en_o;
  assign accept  = cfg_wr && !blocked;
  // halt write wins over a same-cycle commit
  assign commit  = halt_upd_o && !strb_i.wr_halt && (!busy_i || char_bound_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_en_o  <= 1'b0;
      halt_upd_o <= 1'b0;
    end else if (strb_i.wr_halt) begin
      halt_en_o  <= wdata_i[HALT_EN_BIT];
      halt_upd_o <= wdata_i[HALT_UPD_BIT];
    end else if (commit) begin
      halt_upd_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              busy_irq_o <= 1'b0;
    else if (blocked)         busy_irq_o <= 1'b1;
    else if (strb_i.rd_usr)   busy_irq_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_lcr_o  <= '0;
      act_lcr_o <= '0;
    end else begin
      if (accept && strb_i.wr_lcr) sh_lcr_o <= wdata_i;
      if (commit)                  act_lcr_o <= sh_lcr_o;
      if (direct && strb_i.wr_lcr) act_lcr_o <= wdata_i;
    end
  end

  for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_div_o[b*DATA_W +: DATA_W]  <= '0;
        act_div_o[b*DATA_W +: DATA_W] <= '0;
      end else begin
        if (accept && strb_i.wr_div[b]) sh_div_o[b*DATA_W +: DATA_W] <= wdata_i;
        if (commit) act_div_o[b*DATA_W +: DATA_W] <= sh_div_o[b*DATA_W +: DATA_W];
        if (direct && strb_i.wr_div[b]) act_div_o[b*DATA_W +: DATA_W] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/uart_cfg_iir.sv
`timescale 1ns/1ps
module uart_cfg_iir
  import uart_cfg_pkg::*;
(
  input  logic      rls_i,
  input  logic      rxd_i,
  input  logic      thre_i,
  input  logic      busy_i,
  output iir_code_e code_o,
  output logic      irq_o
);
  always_comb begin
    if (rls_i)       code_o = IIR_RLS;
    else if (rxd_i)  code_o = IIR_RXD;
    else if (thre_i) code_o = IIR_THRE;
    else if (busy_i) code_o = IIR_BUSY;
    else             code_o = IIR_NONE;
  end
  assign irq_o = rls_i || rxd_i || thre_i || busy_i;
endmodule

// File: rtl/uart_lcr_guard.sv
`timescale 1ns/1ps
module uart_lcr_guard
  import uart_cfg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LVL_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              busy_i,
  input  logic              char_bound_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rls_irq_i,
  input  logic              rx_irq_i,
  input  logic              thre_irq_i,
  output logic [7:0]        lcr_o,
  output logic [15:0]       divisor_o,
  output logic              tx_push_o,
  output logic [7:0]        tx_data_o,
  output logic              irq_o
);
  cfg_strobe_t       strb;
  logic [DATA_W-1:0] sh_lcr;
  logic [DIV_W-1:0]  sh_div;
  logic              halt_en, halt_upd, busy_irq, dlab;
  iir_code_e         iir_code;
  logic [7:0]        rd_mux;

  assign dlab = sh_lcr[LCR_DLAB_BIT];

  uart_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (reg_addr_i),
    .wr_i   (reg_wr_i),
    .rd_i   (reg_rd_i),
    .dlab_i (dlab),
    .strb_o (strb)
  );

  uart_cfg_shadow u_shadow (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strb_i       (strb),
    .wdata_i      (reg_wdata_i),
    .busy_i       (busy_i),
    .char_bound_i (char_bound_i),
    .act_lcr_o    (lcr_o),
    .act_div_o    (divisor_o),
    .sh_lcr_o     (sh_lcr),
    .sh_div_o     (sh_div),
    .halt_en_o    (halt_en),
    .halt_upd_o   (halt_upd),
    .busy_irq_o   (busy_irq)
  );

  uart_cfg_iir u_iir (
    .rls_i  (rls_irq_i),
    .rxd_i  (rx_irq_i),
    .thre_i (thre_irq_i),
    .busy_i (busy_irq),
    .code_o (iir_code),
    .irq_o  (irq_o)
  );

  assign tx_push_o = strb.wr_thr;
  assign tx_data_o = reg_wdata_i;

  always_comb begin
    rd_mux = '0;
    if (dlab && reg_addr_i < ADDR_W'(DIV_BYTES)) begin
      for (int b = 0; b < DIV_BYTES; b++)
        if (reg_addr_i == ADDR_W'(b)) rd_mux = sh_div[b*DATA_W +: DATA_W];
    end else begin
      case (reg_addr_i)
        ADDR_W'(0):        rd_mux = rx_data_i;
        ADDR_W'(IDX_IIR):  rd_mux = {4'b0, iir_code};
        ADDR_W'(IDX_LCR):  rd_mux = sh_lcr;
        ADDR_W'(IDX_USR):  rd_mux = {7'b0, busy_i};
        ADDR_W'(IDX_TFL):  rd_mux = 8'(tx_level_i);
        ADDR_W'(IDX_RFL):  rd_mux = 8'(rx_level_i);
        ADDR_W'(IDX_HALT): rd_mux = 8'((32'(halt_upd) << HALT_UPD_BIT) |
                                       (32'(halt_en) << HALT_EN_BIT));
        default:           rd_mux = '0;
      endcase
    end
  end

  assign reg_rdata_o = reg_rd_i ? rd_mux : '0;
endmodule

// File: rtl/uart_lcr_guard_chk.sv
`timescale 1ns/1ps
module uart_lcr_guard_chk
  import uart_cfg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rdata_o,
  input logic              busy_i,
  input logic              char_bound_i,
  input logic              rls_irq_i,
  input logic [7:0]        lcr_o,
  input logic [15:0]       divisor_o,
  input logic              irq_o,
  input logic              halt_en,
  input logic              halt_upd,
  input logic              busy_irq
);
  logic lcr_wr, halt_wr;
  assign lcr_wr  = reg_wr_i && (reg_addr_i == ADDR_W'(IDX_LCR));
  assign halt_wr = reg_wr_i && (reg_addr_i == ADDR_W'(IDX_HALT));

  // R2
  direct_lcr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr_wr && !busy_i && !halt_en |=> lcr_o == $past(reg_wdata_i));

  // R3
  refused_lcr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr_wr && busy_i && !halt_en && !halt_upd |=> $stable(lcr_o));

  // R3
  refused_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr_wr && busy_i && !halt_en |=> irq_o);

  // R4
  usr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i && !reg_wr_i && reg_addr_i == ADDR_W'(IDX_USR) |=> !busy_irq);

  // R6
  staged_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_en && !halt_upd |=> $stable(lcr_o) && $stable(divisor_o));

  // R7
  commit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_upd && !busy_i && !halt_wr |=> !halt_upd);

  // R7
  commit_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_upd && busy_i && !char_bound_i && !halt_wr |=> halt_upd);

  // R9
  rls_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rls_irq_i && reg_rd_i && reg_addr_i == ADDR_W'(IDX_IIR) |-> reg_rdata_o[3:0] == 4'h6);
endmodule

bind uart_lcr_guard uart_lcr_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_addr_i   (reg_addr_i),
  .reg_wr_i     (reg_wr_i),
  .reg_rd_i     (reg_rd_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .busy_i       (busy_i),
  .char_bound_i (char_bound_i),
  .rls_irq_i    (rls_irq_i),
  .lcr_o        (lcr_o),
  .divisor_o    (divisor_o),
  .irq_o        (irq_o),
  .halt_en      (halt_en),
  .halt_upd     (halt_upd),
  .busy_irq     (busy_irq)
);

// File: tb/sim_uart_lcr_guard.sv
`timescale 1ns/1ps
module sim_uart_lcr_guard;
  localparam int N = 53;
  // entry: kind[35:32] busy[31] bound[30] addr[29:24] data[23:8] req[7:0]
  localparam logic [3:0] K_WR = 4'd0, K_RD = 4'd1, K_LCR = 4'd2,
                         K_DIV = 4'd3, K_IRQ = 4'd4, K_IDL = 4'd5;
  localparam logic [35:0] VEC [N] = '{
    // R1 reset state
    {K_RD ,1'b0,1'b0,6'd2 ,16'h0001,8'd1},
    {K_LCR,1'b0,1'b0,6'd0 ,16'h0000,8'd1},
    {K_DIV,1'b0,1'b0,6'd0 ,16'h0000,8'd1},
    {K_RD ,1'b0,1'b0,6'd41,16'h0000,8'd1},
    {K_IRQ,1'b0,1'b0,6'd0 ,16'h0000,8'd1},
    // R2 direct writes, R8 divisor access
    {K_WR ,1'b0,1'b0,6'd3 ,16'h0083,8'd2},
    {K_LCR,1'b0,1'b0,6'd0 ,16'h0083,8'd2},
    {K_WR ,1'b0,1'b0,6'd0 ,16'h001A,8'd2},
    {K_WR ,1'b0,1'b0,6'd1 ,16'h0000,8'd2},
    {K_DIV,1'b0,1'b0,6'd0 ,16'h001A,8'd2},
    {K_RD ,1'b0,1'b0,6'd0 ,16'h001A,8'd8},
    {K_WR ,1'b0,1'b0,6'd3 ,16'h0003,8'd2},
    {K_LCR,1'b0,1'b0,6'd0 ,16'h0003,8'd2},
    {K_RD ,1'b0,1'b0,6'd0 ,16'h005C,8'd8},
    // R3 refused while busy
    {K_WR ,1'b1,1'b0,6'd3 ,16'h001B,8'd3},
    {K_LCR,1'b1,1'b0,6'd0 ,16'h0003,8'd3},
    {K_RD ,1'b1,1'b0,6'd2 ,16'h0007,8'd3},
    {K_IRQ,1'b1,1'b0,6'd0 ,16'h0001,8'd3},
    // R4 status read clears
    {K_RD ,1'b1,1'b0,6'd31,16'h0001,8'd4},
    {K_RD ,1'b0,1'b0,6'd2 ,16'h0001,8'd4},
    {K_RD ,1'b0,1'b0,6'd31,16'h0000,8'd4},
    // R5 level registers read-only
    {K_WR ,1'b0,1'b0,6'd32,16'h00FF,8'd5},
    {K_RD ,1'b0,1'b0,6'd32,16'h0021,8'd5},
    {K_RD ,1'b0,1'b0,6'd33,16'h0010,8'd5},
    // R6 staging while busy
    {K_WR ,1'b1,1'b0,6'd41,16'h0002,8'd6},
    {K_WR ,1'b1,1'b0,6'd3 ,16'h0083,8'd6},
    {K_WR ,1'b1,1'b0,6'd0 ,16'h0034,8'd6},
    {K_WR ,1'b1,1'b0,6'd1 ,16'h0012,8'd6},
    {K_WR ,1'b1,1'b0,6'd3 ,16'h0007,8'd6},
    {K_LCR,1'b1,1'b0,6'd0 ,16'h0003,8'd6},
    {K_DIV,1'b1,1'b0,6'd0 ,16'h001A,8'd6},
    {K_RD ,1'b1,1'b0,6'd3 ,16'h0007,8'd6},
    {K_RD ,1'b1,1'b0,6'd2 ,16'h0001,8'd6},
    // R7 commit on character boundary
    {K_WR ,1'b1,1'b0,6'd41,16'h0006,8'd7},
    {K_RD ,1'b1,1'b0,6'd41,16'h0006,8'd7},
    {K_LCR,1'b1,1'b0,6'd0 ,16'h0003,8'd7},
    {K_IDL,1'b1,1'b1,6'd0 ,16'h0000,8'd7},
    {K_LCR,1'b1,1'b0,6'd0 ,16'h0007,8'd7},
    {K_DIV,1'b1,1'b0,6'd0 ,16'h1234,8'd7},
    {K_RD ,1'b1,1'b0,6'd41,16'h0002,8'd7},
    // R3 again after leaving staging
    {K_WR ,1'b1,1'b0,6'd41,16'h0000,8'd3},
    {K_WR ,1'b1,1'b0,6'd3 ,16'h001B,8'd3},
    {K_RD ,1'b1,1'b0,6'd2 ,16'h0007,8'd3},
    {K_RD ,1'b1,1'b0,6'd31,16'h0001,8'd4},
    {K_RD ,1'b0,1'b0,6'd2 ,16'h0001,8'd4},
    // R10 divisor write refused
    {K_WR ,1'b0,1'b0,6'd3 ,16'h0080,8'd10},
    {K_LCR,1'b0,1'b0,6'd0 ,16'h0080,8'd10},
    {K_WR ,1'b1,1'b0,6'd0 ,16'h0055,8'd10},
    {K_DIV,1'b0,1'b0,6'd0 ,16'h1234,8'd10},
    {K_RD ,1'b0,1'b0,6'd2 ,16'h0007,8'd10},
    {K_RD ,1'b0,1'b0,6'd31,16'h0000,8'd4},
    {K_RD ,1'b0,1'b0,6'd0 ,16'h0034,8'd8},
    {K_RD ,1'b0,1'b0,6'd2 ,16'h0001,8'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, busy = 1'b0, bound = 1'b0;
  logic [7:0]  wdata = '0, rdata, lcr, txd;
  logic [15:0] div;
  logic        push, irq;
  logic        rls = 1'b0, rxi = 1'b0, thre = 1'b0;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  uart_lcr_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .busy_i(busy), .char_bound_i(bound),
    .tx_level_i(7'h21), .rx_level_i(7'h10), .rx_data_i(8'h5C),
    .rls_irq_i(rls), .rx_irq_i(rxi), .thre_irq_i(thre),
    .lcr_o(lcr), .divisor_o(div), .tx_push_o(push), .tx_data_o(txd), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [7:0] d, input logic b);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; rd = 1'b0; busy = b; bound = 1'b0;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input string req, input logic [5:0] a, input logic [7:0] exp);
    addr = a; rd = 1'b1; #1;
    chk(req, 16'(rdata), 16'(exp));
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      logic [35:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[7:0], i);
      @(negedge clk);
      addr = v[29:24]; busy = v[31]; bound = v[30]; wdata = v[15:8];
      wr = (v[35:32] == K_WR); rd = (v[35:32] == K_RD);
      #1;
      case (v[35:32])
        K_RD:  chk(tag, 16'(rdata), {8'h00, v[15:8]});
        K_LCR: chk(tag, 16'(lcr), {8'h00, v[15:8]});
        K_DIV: chk(tag, div, v[23:8]);
        K_IRQ: chk(tag, 16'(irq), {15'h0, v[8]});
        default: ;
      endcase
    end
    @(negedge clk); wr = 1'b0; rd = 1'b0; busy = 1'b0; bound = 1'b0;

    // R9 priority ladder with busy pending (lcr is 0x80, write refused)
    bus_wr(6'd3, 8'h00, 1'b1);
    busy = 1'b0;
    thre = 1'b1; bus_rd("R9 thre", 6'd2, 8'h02);
    rxi  = 1'b1; bus_rd("R9 rxd", 6'd2, 8'h04);
    rls  = 1'b1; bus_rd("R9 rls", 6'd2, 8'h06);
    rls = 1'b0; rxi = 1'b0; thre = 1'b0;
    bus_rd("R9 busy", 6'd2, 8'h07);
    chk("R9 irq", 16'(irq), 16'd1);
    bus_rd("R4 usr", 6'd31, 8'h00);
    bus_rd("R4 iir", 6'd2, 8'h01);
    chk("R9 irq idle", 16'(irq), 16'd0);

    // R7 commit with engine idle
    bus_wr(6'd41, 8'h02, 1'b0);
    bus_wr(6'd3, 8'h03, 1'b0);
    chk("R6 lcr held", 16'(lcr), 16'h0080);
    bus_wr(6'd41, 8'h06, 1'b0);
    chk("R7 not yet", 16'(lcr), 16'h0080);
    @(negedge clk);
    chk("R7 idle commit", 16'(lcr), 16'h0003);
    bus_rd("R7 upd cleared", 6'd41, 8'h02);
    bus_wr(6'd41, 8'h00, 1'b0);

    // R8 transmit push with divisor access off
    @(negedge clk);
    addr = 6'd0; wdata = 8'hA5; wr = 1'b1; #1;
    chk("R8 push", 16'(push), 16'd1);
    chk("R8 txdata", 16'(txd), 16'h00A5);
    @(negedge clk); wr = 1'b0;
    chk("R8 div untouched", div, 16'h1234);

    // R1 reset in mid-run
    rst_n = 1'b0; #1;
    chk("R1 lcr", 16'(lcr), 16'h0000);
    chk("R1 div", div, 16'h0000);
    bus_rd("R1 halt", 6'd41, 8'h00);
    chk("R1 irq", 16'(irq), 16'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule